// File: doc/BRIEF.md
# Microcoded Accumulator CPU

This block is a small accumulator processor whose sequencing is driven entirely by a 16-entry read-only control store. A shared internal bus links the program counter, memory address register, memory data register, instruction register, accumulator and an ALU holding register. Each clock, a 20-bit microword is registered. Its 14 control bits gate register transfers and the memory strobes. Its sequencing fields pick the next microword: a 4-bit next address, an opcode-dispatch flag, and a flag that ORs the accumulator-zero condition into the lowest next-address bit.

Instructions are 8 bits wide. A 2-bit opcode selects load, add, store or branch-if-accumulator-zero, and a 6-bit field gives the memory address. The block talks to a simple memory through an address, a write-data bus, a read-data bus and read and write strobes. Read data must be valid within the read microcycle. Every instruction begins with a four-microword fetch. A taken branch passes through a dedicated microword that reloads the PC and MAR, then re-enters fetch one step past its first microword.

Top module: `ucpu_top`

## Requirements
- R1: While rst_ni is low, all architectural registers are zero, the active microword is the first fetch step, and mem_rd_o, mem_wr_o, mem_addr_o and mem_wdata_o are all 0.
- R2: In the first cycle after reset release, mem_rd_o is 1 and mem_addr_o equals the PC (0). Each fetch reads the instruction at the PC and increments the PC by one.
- R3: Load (opcode 00) sets ACC to the memory byte at the address field and takes 7 cycles including fetch.
- R4: Add (opcode 01) sets ACC to ACC plus the addressed memory byte, modulo 256, and takes 8 cycles including fetch.
- R5: Store (opcode 10) asserts mem_wr_o for exactly one cycle, the 7th cycle of the instruction, with mem_addr_o equal to the address field and mem_wdata_o equal to ACC.
- R6: Branch (opcode 11) with ACC equal to 0 loads the address field into the PC, takes 6 cycles, and the next instruction is fetched from the target address.
- R7: Branch with ACC nonzero changes nothing, takes 5 cycles, and execution continues at the following instruction.
- R8: The instruction encoding is opcode in bits [7:6] and address in bits [5:0]. The dispatch microword sends opcode 00/01/10/11 to microwords 5/8/12/15.
- R9: mem_rd_o and mem_wr_o are never asserted in the same cycle, and at most one source drives the internal bus in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 6 | Memory address (MAR) |
| mem_wdata_o | output | 8 | Memory write data (MDR) |
| mem_rdata_i | input | 8 | Memory read data, valid in the read cycle |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |

## Verification
A short load/add/store program pins down the per-instruction cycle counts by recording which address each read strobe carries in each cycle and when the single write appears. Two branch programs, one starting with a zero accumulator and one with a nonzero accumulator, separate the taken path (six cycles, re-entry at the target) from the fall-through path (five cycles). A sweep over operand pairs checks load and add arithmetic, including carries that wrap past 255. A sweep over branch operands, with zero among them, checks that only a zero accumulator selects the branch target.

// File: rtl/ucpu_pkg.sv
package ucpu_pkg;

  localparam int OPC_W = 2;
  localparam int UPC_W = 4;

  typedef logic [UPC_W-1:0] upc_t;

  typedef enum logic [OPC_W-1:0] {
    OP_LOAD  = 2'b00,
    OP_ADD   = 2'b01,
    OP_STORE = 2'b10,
    OP_BZ    = 2'b11
  } opcode_e;

  // control bits, MSB first
  typedef struct packed {
    logic acc_in;
    logic acc_out;
    logic alu_add;
    logic ir_in;
    logic ir_out;
    logic mar_in;
    logic mdr_in;
    logic mdr_out;
    logic pc_in;
    logic pc_out;
    logic pc_inc;
    logic mem_rd;
    logic temp_out;
    logic mem_wr;
  } ctl_t;

  typedef struct packed {
    ctl_t ctl;
    logic dispatch;
    upc_t next;
    logic or_zero;
  } uword_t;

  localparam upc_t UPC_BR_TGT = 4'd1;

  function automatic upc_t dispatch_tgt(logic [OPC_W-1:0] op);
    case (op)
      OP_LOAD:  return 4'd5;
      OP_ADD:   return 4'd8;
      OP_STORE: return 4'd12;
      default:  return 4'd15;
    endcase
  endfunction

  function automatic uword_t ucode_rom(upc_t a);
    uword_t w;
    w = '0;
    case (a)
      4'd0:  begin w.ctl.pc_out = 1'b1; w.ctl.mar_in = 1'b1; w.next = 4'd2; end
      // taken-branch landing: PC and MAR both take the target
      4'd1:  begin w.ctl.ir_out = 1'b1; w.ctl.pc_in = 1'b1; w.ctl.mar_in = 1'b1; w.next = 4'd2; end
      4'd2:  begin w.ctl.mem_rd = 1'b1; w.ctl.pc_inc = 1'b1; w.next = 4'd3; end
      4'd3:  begin w.ctl.mdr_out = 1'b1; w.ctl.ir_in = 1'b1; w.next = 4'd4; end
      4'd4:  begin w.dispatch = 1'b1; end
      4'd5:  begin w.ctl.ir_out = 1'b1; w.ctl.mar_in = 1'b1; w.next = 4'd6; end
      4'd6:  begin w.ctl.mem_rd = 1'b1; w.next = 4'd7; end
      4'd7:  begin w.ctl.mdr_out = 1'b1; w.ctl.acc_in = 1'b1; w.next = 4'd0; end
      4'd8:  begin w.ctl.ir_out = 1'b1; w.ctl.mar_in = 1'b1; w.next = 4'd9; end
      4'd9:  begin w.ctl.mem_rd = 1'b1; w.next = 4'd10; end
      4'd10: begin w.ctl.acc_out = 1'b1; w.ctl.alu_add = 1'b1; w.next = 4'd11; end
      4'd11: begin w.ctl.temp_out = 1'b1; w.ctl.acc_in = 1'b1; w.next = 4'd0; end
      4'd12: begin w.ctl.ir_out = 1'b1; w.ctl.mar_in = 1'b1; w.next = 4'd13; end
      4'd13: begin w.ctl.acc_out = 1'b1; w.ctl.mdr_in = 1'b1; w.next = 4'd14; end
      4'd14: begin w.ctl.mem_wr = 1'b1; w.next = 4'd0; end
      default: begin w.or_zero = 1'b1; w.next = 4'd0; end
    endcase
    return w;
  endfunction

endpackage

// File: rtl/ucpu_cstore.sv
module ucpu_cstore
  import ucpu_pkg::*;
(
  input  upc_t   addr_i,
  output uword_t word_o
);
  assign word_o = ucode_rom(addr_i);
endmodule

// File: rtl/ucpu_seq.sv
module ucpu_seq
  import ucpu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             acc_zero_i,
  output ctl_t             ctl_o
);
  upc_t   upc_q, upc_d;
  uword_t uw_q, uw_d;

  always_comb begin
    if (uw_q.dispatch) upc_d = dispatch_tgt(opcode_i);
    else               upc_d = uw_q.next | {{(UPC_W-1){1'b0}}, uw_q.or_zero & acc_zero_i};
  end

  ucpu_cstore u_cstore (
    .addr_i (upc_d),
    .word_o (uw_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upc_q <= '0;
      uw_q  <= ucode_rom('0);
    end else begin
      upc_q <= upc_d;
      uw_q  <= uw_d;
    end
  end

  assign ctl_o = uw_q.ctl;

  a_r8_dispatch_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uw_q.dispatch && opcode_i == 2'b00) |=> upc_q == 4'd5);
  a_r8_dispatch_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uw_q.dispatch && opcode_i == 2'b01) |=> upc_q == 4'd8);
  a_r6_branch_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_q == 4'd15 && acc_zero_i) |=> upc_q == UPC_BR_TGT);
  a_r7_branch_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_q == 4'd15 && !acc_zero_i) |=> upc_q == 4'd0);
  a_r6_land_refetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_q == UPC_BR_TGT) |=> upc_q == 4'd2);

endmodule

// File: rtl/ucpu_dp.sv
module ucpu_dp
  import ucpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_t              ctl_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [OPC_W-1:0]  opcode_o,
  output logic              acc_zero_o
);
  logic [DATA_W-1:0] acc_q, temp_q, mdr_q, ir_q, bus;
  logic [ADDR_W-1:0] pc_q, mar_q;

  always_comb begin
    bus = '0;
    if (ctl_i.acc_out)  bus = bus | acc_q;
    if (ctl_i.temp_out) bus = bus | temp_q;
    if (ctl_i.mdr_out)  bus = bus | mdr_q;
    if (ctl_i.ir_out)   bus = bus | DATA_W'(ir_q[ADDR_W-1:0]);
    if (ctl_i.pc_out)   bus = bus | DATA_W'(pc_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      temp_q <= '0;
      mdr_q  <= '0;
      ir_q   <= '0;
      pc_q   <= '0;
      mar_q  <= '0;
    end else begin
      if (ctl_i.acc_in)  acc_q  <= bus;
      if (ctl_i.alu_add) temp_q <= acc_q + mdr_q;
      if (ctl_i.ir_in)   ir_q   <= bus;
      if (ctl_i.mar_in)  mar_q  <= bus[ADDR_W-1:0];
      if (ctl_i.mem_rd)      mdr_q <= mem_rdata_i;
      else if (ctl_i.mdr_in) mdr_q <= bus;
      if (ctl_i.pc_in)       pc_q <= bus[ADDR_W-1:0];
      else if (ctl_i.pc_inc) pc_q <= pc_q + ADDR_W'(1);
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mdr_q;
  assign opcode_o    = ir_q[DATA_W-1 -: OPC_W];
  assign acc_zero_o  = (acc_q == '0);

  a_r9_single_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctl_i.acc_out, ctl_i.temp_out, ctl_i.mdr_out, ctl_i.ir_out, ctl_i.pc_out}));
  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.pc_inc && !ctl_i.pc_in) |=> pc_q == ADDR_W'($past(pc_q) + ADDR_W'(1)));
  a_r4_sum_captured: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.alu_add |=> temp_q == DATA_W'($past(acc_q) + $past(mdr_q)));

endmodule

// File: rtl/ucpu_top.sv
module ucpu_top
  import ucpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o
);
  ctl_t             ctl;
  logic [OPC_W-1:0] opcode;
  logic             acc_zero;

  ucpu_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .opcode_i   (opcode),
    .acc_zero_i (acc_zero),
    .ctl_o      (ctl)
  );

  ucpu_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_i       (ctl),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .opcode_o    (opcode),
    .acc_zero_o  (acc_zero)
  );

  assign mem_rd_o = ctl.mem_rd;
  assign mem_wr_o = ctl.mem_wr;

  a_r9_no_rw_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  a_r5_write_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> !mem_wr_o);

endmodule

// File: tb/ucpu_top_test.sv
module ucpu_top_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic       mem_rd, mem_wr;

  logic [7:0] mem [64];
  int total = 0, bad = 0;
  int cyc;
  int first_wr, wr_cnt, both_cnt;
  int rd_log [32];
  bit done = 1'b0;

  always #10 clk = ~clk;

  ucpu_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) if (rst_ni && mem_wr) mem[mem_addr] = mem_wdata;

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) cyc <= 0; else cyc <= cyc + 1;

  always @(negedge clk) if (rst_ni) begin
    if (cyc < 32) rd_log[cyc] = mem_rd ? int'(mem_addr) : -1;
    if (mem_wr) begin
      wr_cnt = wr_cnt + 1;
      if (first_wr < 0) first_wr = cyc;
    end
    if (mem_rd && mem_wr) both_cnt = both_cnt + 1;
  end

  function automatic logic [7:0] ins(logic [1:0] op, int a);
    return {op, 6'(a)};
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    rst_ni = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    for (int i = 0; i < 32; i++) rd_log[i] = -1;
    first_wr = -1; wr_cnt = 0; both_cnt = 0;
  endtask

  task automatic run(int n);
    @(negedge clk) rst_ni = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // timing program: LOAD 40, ADD 41, STORE 42, LOAD 43, BZ 4
    clear_all();
    mem[0] = ins(2'b00, 40); mem[1] = ins(2'b01, 41); mem[2] = ins(2'b10, 42);
    mem[3] = ins(2'b00, 43); mem[4] = ins(2'b11, 4);
    mem[40] = 8'd100; mem[41] = 8'd23;
    repeat (3) @(negedge clk);
    check("R1 rd", int'(mem_rd), 0);
    check("R1 wr", int'(mem_wr), 0);
    check("R1 addr", int'(mem_addr), 0);
    check("R1 wdata", int'(mem_wdata), 0);
    run(80);
    check("R2 first fetch addr", rd_log[1], 0);
    check("R3 operand read", rd_log[5], 40);
    check("R3 load 7 cycles", rd_log[8], 1);
    check("R4 add 8 cycles", rd_log[16], 2);
    check("R5 write cycle", first_wr, 21);
    check("R5 write count", wr_cnt, 1);
    check("R4 sum", int'(mem[42]), 123);
    check("R9 rd/wr overlap", both_cnt, 0);

    // taken branch with ACC zero from reset
    clear_all();
    mem[0] = ins(2'b11, 4); mem[1] = ins(2'b10, 61);
    mem[4] = ins(2'b10, 60); mem[5] = ins(2'b11, 5);
    mem[60] = 8'hAA; mem[61] = 8'h55;
    repeat (2) @(negedge clk);
    run(40);
    check("R6 refetch at target", rd_log[6], 4);
    check("R6 taken 6 cycles", first_wr, 11);
    check("R6 stored acc", int'(mem[60]), 0);
    check("R6 skipped slot", int'(mem[61]), 8'h55);

    // not-taken branch
    clear_all();
    mem[0] = ins(2'b00, 62); mem[1] = ins(2'b11, 10); mem[2] = ins(2'b10, 61);
    mem[3] = ins(2'b00, 63); mem[4] = ins(2'b11, 4); mem[10] = ins(2'b10, 59);
    mem[62] = 8'd77; mem[59] = 8'h33;
    repeat (2) @(negedge clk);
    run(60);
    check("R7 next fetch", rd_log[13], 2);
    check("R7 fall 5 cycles", first_wr, 18);
    check("R7 stored", int'(mem[61]), 77);
    check("R7 target unused", int'(mem[59]), 8'h33);

    // load/add sweep
    for (int a = 0; a < 256; a += 37) begin
      for (int b = 0; b < 256; b += 53) begin
        clear_all();
        mem[0] = ins(2'b00, 40); mem[1] = ins(2'b10, 44); mem[2] = ins(2'b01, 41);
        mem[3] = ins(2'b10, 42); mem[4] = ins(2'b00, 43); mem[5] = ins(2'b11, 5);
        mem[40] = 8'(a); mem[41] = 8'(b);
        repeat (2) @(negedge clk);
        run(60);
        check("R3 load value", int'(mem[44]), a);
        check("R4 wrapped sum", int'(mem[42]), (a + b) % 256);
      end
    end

    // branch decision sweep
    for (int x = 0; x < 256; x += 17) begin
      for (int k = 0; k < 2; k++) begin
        int v;
        v = (k == 0) ? x : 0;
        clear_all();
        mem[0] = ins(2'b00, 40); mem[1] = ins(2'b11, 6); mem[2] = ins(2'b00, 41);
        mem[3] = ins(2'b10, 42); mem[4] = ins(2'b00, 43); mem[5] = ins(2'b11, 5);
        mem[6] = ins(2'b00, 44); mem[7] = ins(2'b10, 42); mem[8] = ins(2'b00, 43);
        mem[9] = ins(2'b11, 9);
        mem[40] = 8'(v); mem[41] = 8'h11; mem[44] = 8'h22;
        repeat (2) @(negedge clk);
        run(60);
        check("R6 R7 R8 branch select", int'(mem[42]), (v == 0) ? 8'h22 : 8'h11);
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule